// File: doc/BRIEF.md
# Converter Mode Programming Sequencer

This block loads a configuration byte into an external integrating converter through the converter's own control pins. On a start request it takes the requested input channel, line-frequency rejection and resolution, builds the control byte, and puts that byte on the shared data bus. It then runs the converter's load handshake: it raises the mode-select line, lowers output-enable, holds convert low until the status pair reports ready, and finally releases the lines in order. An optional autozero pulse can run before the write. Autozero returns the converter to its defaults, so the block always writes the requested byte after it.

A resolution request outside the legal codes is refused: the error flag is raised and no pin moves. If the status pair never returns to ready, a timeout counter aborts the write. The done and error flags tell the caller how the last sequence ended. The status pair comes from another clock domain and passes through a synchroniser of selectable depth.

Top module: `msq_mode_seq`

## Requirements
- R1: The control byte is {2'b00, 1'b0, chan_sel_i, line50_i, res_code_i}. Bit 4 is 0 for the primary input and 1 for the secondary input. Bit 3 is 0 for 60 Hz and 1 for 50 Hz. Bits 2:0 are 001, 010, 011 or 100 for 18, 20, 22 or 24 bits.
- R2: A start with res_code_i of 000, 101, 110 or 111 sets err_o and clears done_o one cycle later. mode_sel_o, cfg_drive_o, oe_n_o, conv_n_o and az_n_o do not move.
- R3: After an accepted start without autozero, mode_sel_o and cfg_drive_o rise one cycle later. oe_n_o falls SETUP_CYC cycles after that, and conv_n_o falls PULSE_CYC cycles after oe_n_o.
- R4: conv_n_o stays low until the synchronised status has left 2'b11 and then returned to 2'b11. conv_n_o and oe_n_o then rise together SYNC_STAGES+1 cycles after the status returns. mode_sel_o falls PULSE_CYC cycles later, and done_o rises in that same cycle.
- R5: If the write has not completed TIMEOUT_CYC cycles after conv_n_o falls, conv_n_o, oe_n_o, mode_sel_o and cfg_drive_o are all released in that cycle. err_o is set and done_o stays clear.
- R6: With az_req_i set at start, az_n_o is low for AZ_CYC cycles starting one cycle after the start. mode_sel_o rises AZ_REC_CYC cycles after az_n_o returns high, and the write then follows as in R3 and R4.
- R7: The request fields are captured at the accepted start. A start pulse or a field change during a sequence has no effect on the written byte and does not start another write.
- R8: During reset, mode_sel_o, cfg_drive_o, done_o and err_o are low, cfg_data_o is zero, and oe_n_o, conv_n_o and az_n_o are high.
- R9: done_o and err_o are never both high. Each holds its value until the next start, which clears both.
- R10: cfg_data_o is zero whenever cfg_drive_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a sequence when the block is idle |
| az_req_i | input | 1 | Run the autozero pulse before the write |
| chan_sel_i | input | 1 | 0 primary input, 1 secondary input |
| line50_i | input | 1 | 0 for 60 Hz rejection, 1 for 50 Hz |
| res_code_i | input | 3 | Resolution code |
| stat_i | input | 2 | Converter status pair (asynchronous) |
| cfg_data_o | output | 8 | Byte driven onto the shared bus |
| cfg_drive_o | output | 1 | Bus drive enable |
| mode_sel_o | output | 1 | Mode-select line, high during the write |
| oe_n_o | output | 1 | Output-enable line, active low |
| conv_n_o | output | 1 | Convert line, active low |
| az_n_o | output | 1 | Autozero/reset line, active low |
| done_o | output | 1 | Last sequence completed |
| err_o | output | 1 | Last request refused or timed out |

## Verification
A refusal shows on err_o one cycle after the start edge. The line edges are due at fixed offsets from each other: SETUP_CYC, PULSE_CYC, AZ_CYC and AZ_REC_CYC cycles. The release of convert is due SYNC_STAGES+1 cycles after the modelled converter drives status ready. A timeout release is due exactly TIMEOUT_CYC cycles after convert falls. The bench numbers every falling clock edge after the start edge and records the index at which each line first changes. It compares those indices with the offsets computed from the parameters it chose, so an early or late edge of even one cycle is reported.

// File: rtl/msq_pkg.sv
package msq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_AZ,
      ST_AZ_REC,
      ST_SETUP,
      ST_OE_LOW,
      ST_CONV,
      ST_OE_REL
   } msq_state_e;

   localparam logic [1:0] STAT_READY = 2'b11;

   // Resolution codes accepted by the converter
   localparam logic [2:0] RES_LO = 3'b001;
   localparam logic [2:0] RES_HI = 3'b100;

   function automatic int unsigned msq_max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/msq_byte_enc.sv
module msq_byte_enc #(
   parameter int unsigned RES_W  = 3,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              chan_sel,
   input  logic              line50,
   input  logic [RES_W-1:0]  res_code,
   output logic [BYTE_W-1:0] ctl_byte,
   output logic              legal
);
   localparam int unsigned CHAN_BIT = RES_W + 1;
   localparam int unsigned FREQ_BIT = RES_W;

   if (BYTE_W < RES_W + 4) begin : g_bad_width
      $error("msq_byte_enc: BYTE_W too small for the fields");
   end

   always_comb begin
      ctl_byte           = '0;
      ctl_byte[RES_W-1:0] = res_code;
      ctl_byte[FREQ_BIT]  = line50;
      ctl_byte[CHAN_BIT]  = chan_sel;
   end

   assign legal = (res_code >= RES_W'(msq_pkg::RES_LO)) &&
                  (res_code <= RES_W'(msq_pkg::RES_HI));
endmodule

// File: rtl/msq_sync.sv
module msq_sync #(
   parameter int unsigned     WIDTH   = 2,
   parameter int unsigned     STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= RST_VAL;
         end else begin
            stage_q[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
         end
      end
      assign q = stage_q[STAGES-1];
   end
endmodule

// File: rtl/msq_mode_seq.sv
module msq_mode_seq #(
   parameter int unsigned SETUP_CYC   = 16,
   parameter int unsigned PULSE_CYC   = 16,
   parameter int unsigned AZ_CYC      = 1250,
   parameter int unsigned AZ_REC_CYC  = 125000,
   parameter int unsigned TIMEOUT_CYC = 625000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       az_req_i,
   input  logic       chan_sel_i,
   input  logic       line50_i,
   input  logic [2:0] res_code_i,
   input  logic [1:0] stat_i,
   output logic [7:0] cfg_data_o,
   output logic       cfg_drive_o,
   output logic       mode_sel_o,
   output logic       oe_n_o,
   output logic       conv_n_o,
   output logic       az_n_o,
   output logic       done_o,
   output logic       err_o
);
   import msq_pkg::*;

   localparam int unsigned RES_W   = 3;
   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned CNT_MAX = msq_max2(msq_max2(SETUP_CYC, PULSE_CYC),
                                     msq_max2(AZ_CYC, msq_max2(AZ_REC_CYC, TIMEOUT_CYC)));
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

   if (SETUP_CYC < 1 || PULSE_CYC < 1 || AZ_CYC < 1 || AZ_REC_CYC < 1) begin : g_bad_step
      $error("msq_mode_seq: every step length must be at least one cycle");
   end
   if (TIMEOUT_CYC < 2) begin : g_bad_timeout
      $error("msq_mode_seq: TIMEOUT_CYC must be at least two cycles");
   end

   logic [BYTE_W-1:0] enc_byte;
   logic              enc_legal;
   logic [1:0]        stat_s;

   msq_byte_enc #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_enc (
      .chan_sel (chan_sel_i),
      .line50   (line50_i),
      .res_code (res_code_i),
      .ctl_byte (enc_byte),
      .legal    (enc_legal)
   );

   msq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(STAT_READY)) u_stat_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (stat_i),
      .q     (stat_s)
   );

   msq_state_e        st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] byte_q;
   logic              seen_busy_q;
   logic              done_q;
   logic              err_q;
   logic              cnt_zero;

   assign cnt_zero = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         cnt_q       <= '0;
         byte_q      <= '0;
         seen_busy_q <= 1'b0;
         done_q      <= 1'b0;
         err_q       <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  done_q <= 1'b0;
                  if (!enc_legal) begin
                     err_q <= 1'b1;
                  end else begin
                     err_q  <= 1'b0;
                     byte_q <= enc_byte;
                     if (az_req_i) begin
                        st_q  <= ST_AZ;
                        cnt_q <= CNT_W'(AZ_CYC - 1);
                     end else begin
                        st_q  <= ST_SETUP;
                        cnt_q <= CNT_W'(SETUP_CYC - 1);
                     end
                  end
               end
            end
            ST_AZ: begin
               if (cnt_zero) begin
                  st_q  <= ST_AZ_REC;
                  cnt_q <= CNT_W'(AZ_REC_CYC - 1);
               end else cnt_q <= cnt_q - 1'b1;
            end
            ST_AZ_REC: begin
               if (cnt_zero) begin
                  st_q  <= ST_SETUP;
                  cnt_q <= CNT_W'(SETUP_CYC - 1);
               end else cnt_q <= cnt_q - 1'b1;
            end
            ST_SETUP: begin
               if (cnt_zero) begin
                  st_q  <= ST_OE_LOW;
                  cnt_q <= CNT_W'(PULSE_CYC - 1);
               end else cnt_q <= cnt_q - 1'b1;
            end
            ST_OE_LOW: begin
               if (cnt_zero) begin
                  st_q        <= ST_CONV;
                  cnt_q       <= CNT_W'(TIMEOUT_CYC - 1);
                  seen_busy_q <= 1'b0;
               end else cnt_q <= cnt_q - 1'b1;
            end
            ST_CONV: begin
               if (stat_s != STAT_READY) seen_busy_q <= 1'b1;
               if (seen_busy_q && stat_s == STAT_READY) begin
                  st_q  <= ST_OE_REL;
                  cnt_q <= CNT_W'(PULSE_CYC - 1);
               end else if (cnt_zero) begin
                  st_q  <= ST_IDLE;
                  err_q <= 1'b1;
               end else cnt_q <= cnt_q - 1'b1;
            end
            ST_OE_REL: begin
               if (cnt_zero) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
               end else cnt_q <= cnt_q - 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   logic writing;
   assign writing = (st_q == ST_SETUP) || (st_q == ST_OE_LOW) ||
                    (st_q == ST_CONV)  || (st_q == ST_OE_REL);

   assign mode_sel_o  = writing;
   assign cfg_drive_o = writing;
   assign cfg_data_o  = writing ? byte_q : '0;
   assign oe_n_o      = !((st_q == ST_OE_LOW) || (st_q == ST_CONV));
   assign conv_n_o    = (st_q != ST_CONV);
   assign az_n_o      = (st_q != ST_AZ);
   assign done_o      = done_q;
   assign err_o       = err_q;
endmodule

// File: rtl/msq_mode_seq_chk.sv
module msq_mode_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] cfg_data_o,
   input logic       cfg_drive_o,
   input logic       mode_sel_o,
   input logic       oe_n_o,
   input logic       conv_n_o,
   input logic       az_n_o,
   input logic       done_o,
   input logic       err_o
);
   AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_drive_o |-> cfg_data_o[7:5] == 3'b000); // R1

   AST_RES_FIELD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_drive_o |-> (cfg_data_o[2:0] >= 3'd1 && cfg_data_o[2:0] <= 3'd4)); // R1

   AST_OE_WITHIN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n_o |-> mode_sel_o); // R3

   AST_CONV_WITHIN_OE: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_n_o |-> (!oe_n_o && mode_sel_o)); // R4

   AST_DONE_AT_MODE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $fell(mode_sel_o)); // R4

   AST_ERR_LINES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> (!mode_sel_o && oe_n_o && conv_n_o && !cfg_drive_o)); // R5

   AST_AZ_OUTSIDE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !az_n_o |-> !mode_sel_o); // R6

   AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_drive_o && $past(cfg_drive_o)) |-> $stable(cfg_data_o)); // R7

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o)); // R9

   AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_drive_o |-> cfg_data_o == 8'h00); // R10
endmodule

bind msq_mode_seq msq_mode_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_data_o  (cfg_data_o),
   .cfg_drive_o (cfg_drive_o),
   .mode_sel_o  (mode_sel_o),
   .oe_n_o      (oe_n_o),
   .conv_n_o    (conv_n_o),
   .az_n_o      (az_n_o),
   .done_o      (done_o),
   .err_o       (err_o)
);

// File: tb/tb_msq_mode_seq.sv
`timescale 1ns/1ps
module tb_msq_mode_seq;
   localparam int SETUP = 3;
   localparam int PULSE = 2;
   localparam int AZC   = 4;
   localparam int AZREC = 5;
   localparam int TMO   = 60;
   localparam int SYNC  = 2;

   // {az, chan, hz50, res[2:0], exp_err, exp_byte[7:0]}
   localparam logic [14:0] VECS [9] = '{
      15'b0_0_0_011_0_00000011,
      15'b0_1_0_001_0_00010001,
      15'b0_0_1_010_0_00001010,
      15'b0_1_1_100_0_00011100,
      15'b1_1_1_001_0_00011001,
      15'b1_0_0_011_0_00000011,
      15'b0_0_0_000_1_00000000,
      15'b1_1_0_111_1_00000000,
      15'b0_0_1_101_1_00000000
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, az_req_i = 1'b0, chan_sel_i = 1'b0, line50_i = 1'b0;
   logic [2:0] res_code_i = 3'b011;
   logic [1:0] stat;
   logic [7:0] cfg_data_o;
   logic cfg_drive_o, mode_sel_o, oe_n_o, conv_n_o, az_n_o, done_o, err_o;

   always #4 clk = ~clk;

   msq_mode_seq #(.SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .AZ_CYC(AZC),
                  .AZ_REC_CYC(AZREC), .TIMEOUT_CYC(TMO), .SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .az_req_i(az_req_i),
      .chan_sel_i(chan_sel_i), .line50_i(line50_i), .res_code_i(res_code_i),
      .stat_i(stat), .cfg_data_o(cfg_data_o), .cfg_drive_o(cfg_drive_o),
      .mode_sel_o(mode_sel_o), .oe_n_o(oe_n_o), .conv_n_o(conv_n_o),
      .az_n_o(az_n_o), .done_o(done_o), .err_o(err_o));

   // Converter model: busy two edges after convert is seen low, ready 20 edges later
   bit hang = 1'b0;
   int mcnt;
   always @(posedge clk) begin
      if (!rst_n) begin
         stat <= 2'b11; mcnt <= 0;
      end else if (!conv_n_o && mode_sel_o) begin
         mcnt <= mcnt + 1;
         if (mcnt == 1) stat <= 2'b00;
         else if (mcnt == 21 && !hang) stat <= 2'b11;
      end else begin
         mcnt <= 0; stat <= 2'b11;
      end
   end

   int checks = 0, errors = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   int az_fall, az_rise, mode_rise, mode_fall, oe_fall, oe_rise, conv_fall, conv_rise;
   int done_at, err_at, stat_hi, n_rises, bus_bad, d0, e0, done_end;
   logic [7:0] got_byte;

   task automatic run_seq(input bit az, input bit ch, input bit hz, input logic [2:0] res,
                          input bit poke);
      bit seen = 1'b0;
      bit prev_mode = 1'b0;
      az_fall = -1; az_rise = -1; mode_rise = -1; mode_fall = -1; oe_fall = -1;
      oe_rise = -1; conv_fall = -1; conv_rise = -1; done_at = -1; err_at = -1;
      stat_hi = -1; n_rises = 0; bus_bad = 0; got_byte = 8'h00;
      @(negedge clk);
      az_req_i = az; chan_sel_i = ch; line50_i = hz; res_code_i = res; start_i = 1'b1;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (i == 0) begin
            start_i = 1'b0; d0 = done_o; e0 = err_o;
         end
         if (poke && i == 7) begin
            start_i = 1'b1; chan_sel_i = 1'b1; line50_i = 1'b1; res_code_i = 3'b100;
         end
         if (poke && i == 8) start_i = 1'b0;
         if (az_fall < 0 && !az_n_o) az_fall = i;
         if (az_fall >= 0 && az_rise < 0 && az_n_o) az_rise = i;
         if (mode_rise < 0 && mode_sel_o) mode_rise = i;
         if (mode_rise >= 0 && mode_fall < 0 && !mode_sel_o) mode_fall = i;
         if (oe_fall < 0 && !oe_n_o) begin oe_fall = i; got_byte = cfg_data_o; end
         if (oe_fall >= 0 && oe_rise < 0 && oe_n_o) oe_rise = i;
         if (conv_fall < 0 && !conv_n_o) conv_fall = i;
         if (conv_fall >= 0 && conv_rise < 0 && conv_n_o) conv_rise = i;
         if (conv_fall >= 0 && stat != 2'b11) seen = 1'b1;
         if (seen && stat_hi < 0 && stat == 2'b11) stat_hi = i;
         if (done_at < 0 && done_o) done_at = i;
         if (err_at < 0 && err_o) err_at = i;
         if (mode_sel_o && !prev_mode) n_rises++;
         prev_mode = mode_sel_o;
         if ((!cfg_drive_o && cfg_data_o != 8'h00) || (cfg_drive_o != mode_sel_o)) bus_bad++;
      end
      done_end = done_o;
   endtask

   initial begin
      #1;
      // R8 reset state
      @(negedge clk);
      chk(!mode_sel_o && !cfg_drive_o && cfg_data_o == 8'h00, "R8 bus/mode idle", cfg_data_o, 0);
      chk(oe_n_o && conv_n_o && az_n_o && !done_o && !err_o, "R8 lines high flags low",
          {oe_n_o, conv_n_o, az_n_o, done_o, err_o}, 5'b11100);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      foreach (VECS[k]) begin
         automatic logic [14:0] v = VECS[k];
         automatic bit az = v[14];
         automatic int base = az ? (AZC + AZREC) : 0;
         run_seq(az, v[13], v[12], v[11:9], 1'b0);
         chk(bus_bad == 0, "R10 bus zero when not driven", bus_bad, 0);
         if (v[8]) begin
            chk(err_at == 0 && done_at == -1, "R2 refused start flags", err_at, 0);
            chk(mode_rise == -1 && az_fall == -1 && oe_fall == -1 && conv_fall == -1,
                "R2 no pin activity", mode_rise, -1);
         end else begin
            chk(d0 == 0 && e0 == 0, "R9 start clears flags", d0 + e0, 0);
            chk(got_byte == v[7:0], "R1 control byte", got_byte, v[7:0]);
            if (az) begin
               chk(az_fall == 0, "R6 autozero start", az_fall, 0);
               chk(az_rise == AZC, "R6 autozero length", az_rise, AZC);
            end else chk(az_fall == -1, "R6 no autozero", az_fall, -1);
            chk(mode_rise == base, "R3 mode rise", mode_rise, base);
            chk(oe_fall == base + SETUP, "R3 oe fall", oe_fall, base + SETUP);
            chk(conv_fall == oe_fall + PULSE, "R3 convert fall", conv_fall, oe_fall + PULSE);
            chk(conv_rise == stat_hi + SYNC + 1, "R4 convert release", conv_rise, stat_hi + SYNC + 1);
            chk(oe_rise == conv_rise, "R4 oe release", oe_rise, conv_rise);
            chk(mode_fall == oe_rise + PULSE, "R4 mode fall", mode_fall, oe_rise + PULSE);
            chk(done_at == mode_fall && err_at == -1, "R4 done timing", done_at, mode_fall);
            chk(done_end == 1, "R9 done held", done_end, 1);
         end
      end

      // R7: start and field changes during a write are ignored
      run_seq(1'b0, 1'b0, 1'b0, 3'b011, 1'b1);
      chk(got_byte == 8'h03, "R7 byte captured at start", got_byte, 8'h03);
      chk(n_rises == 1, "R7 no second write", n_rises, 1);
      chk(done_at >= 0 && err_at == -1, "R7 write completes", done_at, mode_fall);

      // R5: status never returns ready
      hang = 1'b1;
      run_seq(1'b0, 1'b1, 1'b0, 3'b010, 1'b0);
      hang = 1'b0;
      chk(conv_fall == SETUP + PULSE, "R5 convert fall", conv_fall, SETUP + PULSE);
      chk(mode_fall == conv_fall + TMO, "R5 timeout release", mode_fall, conv_fall + TMO);
      chk(conv_rise == mode_fall && oe_rise == mode_fall, "R5 lines together", conv_rise, mode_fall);
      chk(err_at == mode_fall && done_at == -1, "R5 error flag", err_at, mode_fall);
      chk(bus_bad == 0, "R10 bus zero after abort", bus_bad, 0);

      // R9: a good write after an error clears err
      run_seq(1'b0, 1'b0, 1'b1, 3'b001, 1'b0);
      chk(e0 == 0 && done_at == mode_fall, "R9 error cleared then done", e0, 0);

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual %0d expected %0d", 1, 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule